// File: doc/BRIEF.md
# Oversampled UART Byte Receiver with Error Flags

This block recovers bytes from an asynchronous serial line. It runs on a master clock at sixteen times the bit rate. The line passes through a synchronizer first. The receiver then waits for the line to fall, confirms the start bit at its mid-point, and samples every following bit near its centre.

A frame is one low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. At the end of each frame the block holds the byte and raises a ready flag. It also records whether the parity bit disagreed with the selected sense and whether the stop bit was missing. If a byte arrives while the previous one is still unread, an overrun flag is set.

The host takes the byte with an active-low read strobe. The falling edge of the strobe copies the held byte onto the output bus and clears both ready and overrun.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `ready`, `parity_err`, `frame_err` and `overrun` are 0 and `dout` is 0.
- R2: A low pulse on `rx_line` that has ended before the start bit's mid-point (here 4 clocks long) produces no byte: `ready` stays 0, and a later valid frame is still received correctly.
- R3: Each bit is sampled near its centre. A bit is received correctly when its value is present only on the middle ten of its sixteen clocks and inverted on the first three and last three.
- R4: Eight data bits are received least significant bit first. After the read strobe, `dout` equals the byte sent: bit i of `dout` is the i-th data bit after the start bit.
- R5: With `parity_odd`=0 the parity bit should make the count of ones in data plus parity even; with `parity_odd`=1 it should make that count odd. `parity_err` is 1 after a frame whose parity bit breaks this rule and 0 otherwise.
- R6: A frame whose stop bit is sampled low sets `frame_err` to 1. The receiver then starts no new frame until `rx_line` has returned high, so a break held low after such a frame produces no further byte.
- R7: `ready` rises at the end of a frame. A high-to-low edge on `rd_n` clears `ready` and loads `dout`. A read edge while `ready` is 0 leaves `ready` and `overrun` at 0.
- R8: A frame that completes while `ready` is 1 sets `overrun`. A read edge clears `overrun` and `dout` then shows the newest byte.
- R9: `parity_err` and `frame_err` are rewritten at the end of every frame, so a correct frame clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x16 | input | 1 | Master clock at 16 times the bit rate |
| rst | input | 1 | Asynchronous reset, active high |
| rx_line | input | 1 | Serial input, high when idle |
| rd_n | input | 1 | Read strobe, active low; its falling edge takes the byte |
| parity_odd | input | 1 | Parity sense: 0 even, 1 odd |
| dout | output | DATA_W | Byte delivered by the last read |
| ready | output | 1 | A received byte is waiting to be read |
| parity_err | output | 1 | Last frame had a parity mismatch |
| frame_err | output | 1 | Last frame had a low stop bit |
| overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The bench sweeps every byte value under both parity senses. On half of those frames it corrupts the edges of each data bit. A receiver that samples off-centre, or that shifts bits in the wrong direction, returns wrong bytes. A short low glitch checks that a receiver without mid-point validation does not deliver a phantom byte. A break held low after a bad stop bit checks that the receiver does not restart on the still-low line. Wrong-parity frames, back-to-back unread frames and reads with nothing pending check that each flag is set, cleared and overwritten at the right time, and that an overrun returns the newest byte.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP,
      RX_HUNT
   } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // Reset to the idle level so no false start follows reset.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
   import serial_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_s,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bit,
   output logic              stop_bit
);
   localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         idx      <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         stop_bit <= 1'b1;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            RX_IDLE: begin
               cnt <= '0;
               if (!rx_s) state <= RX_START;
            end
            RX_START: begin
               if (cnt == MID_CNT) begin
                  cnt   <= '0;
                  idx   <= '0;
                  state <= rx_s ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt == LAST_CNT) begin
                  cnt   <= '0;
                  shreg <= {rx_s, shreg[DATA_W-1:1]};
                  idx   <= idx + 1'b1;
                  if (idx == LAST_IDX) state <= RX_PARITY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PARITY: begin
               if (cnt == LAST_CNT) begin
                  cnt     <= '0;
                  par_bit <= rx_s;
                  state   <= RX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (cnt == LAST_CNT) begin
                  cnt      <= '0;
                  stop_bit <= rx_s;
                  done     <= 1'b1;
                  state    <= rx_s ? RX_IDLE : RX_HUNT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_HUNT: begin
               if (rx_s) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign data = shreg;

   assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_glitch_reject_R2: assert property (@(posedge clk) disable iff (rst)
      (state == RX_START && cnt == MID_CNT && rx_s) |=> (state == RX_IDLE));
   assert_hunt_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (state == RX_HUNT && !rx_s) |=> (state == RX_HUNT));
endmodule

// File: rtl/rx_status.sv
module rx_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done,
   input  logic [DATA_W-1:0] data,
   input  logic              par_bit,
   input  logic              stop_bit,
   input  logic              parity_odd,
   input  logic              rd_n,
   output logic [DATA_W-1:0] dout,
   output logic              ready,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun
);
   logic [DATA_W-1:0] hold;
   logic              rd_q;
   logic              rd_fall;

   assign rd_fall = rd_q & ~rd_n;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_q       <= 1'b1;
         hold       <= '0;
         dout       <= '0;
         ready      <= 1'b0;
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         rd_q <= rd_n;
         if (rd_fall) begin
            dout    <= hold;
            ready   <= 1'b0;
            overrun <= 1'b0;
         end
         // A frame ending on the same edge as a read: the old byte is read,
         // the new one becomes pending, and no overrun is recorded.
         if (done) begin
            hold       <= data;
            ready      <= 1'b1;
            overrun    <= (overrun | ready) & ~rd_fall;
            parity_err <= (^data) ^ par_bit ^ parity_odd;
            frame_err  <= ~stop_bit;
         end
      end
   end

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_fall && !done) |=> (!ready && !overrun));
   assert_ready_source_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(ready) |-> $past(done));
   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
      (done && ready && !rd_fall) |=> overrun);
   assert_frame_flag_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> (frame_err == !$past(stop_bit)));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_x16,
   input  logic              rst,
   input  logic              rx_line,
   input  logic              rd_n,
   input  logic              parity_odd,
   output logic [DATA_W-1:0] dout,
   output logic              ready,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("serial_byte_rx: DATA_W must be positive");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("serial_byte_rx: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   logic              rx_s;
   logic              done;
   logic [DATA_W-1:0] data;
   logic              par_bit;
   logic              stop_bit;

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk_x16),
      .rst (rst),
      .d   (rx_line),
      .q   (rx_s)
   );

   rx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk      (clk_x16),
      .rst      (rst),
      .rx_s     (rx_s),
      .done     (done),
      .data     (data),
      .par_bit  (par_bit),
      .stop_bit (stop_bit)
   );

   rx_status #(.DATA_W(DATA_W)) u_status (
      .clk        (clk_x16),
      .rst        (rst),
      .done       (done),
      .data       (data),
      .par_bit    (par_bit),
      .stop_bit   (stop_bit),
      .parity_odd (parity_odd),
      .rd_n       (rd_n),
      .dout       (dout),
      .ready      (ready),
      .parity_err (parity_err),
      .frame_err  (frame_err),
      .overrun    (overrun)
   );
endmodule

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic       rd_n = 1'b1;
   logic       parity_odd = 1'b0;
   logic [7:0] dout;
   logic       ready, parity_err, frame_err, overrun;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   serial_byte_rx u_serial_byte_rx (
      .clk_x16    (clk),
      .rst        (rst),
      .rx_line    (rx_line),
      .rd_n       (rd_n),
      .parity_odd (parity_odd),
      .dout       (dout),
      .ready      (ready),
      .parity_err (parity_err),
      .frame_err  (frame_err),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Status packed as {ready, parity_err, frame_err, overrun}.
   function automatic int st();
      return {ready, parity_err, frame_err, overrun};
   endfunction

   task automatic drive_bit(input logic v, input bit noisy);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         rx_line = (noisy && (k < 3 || k > 12)) ? ~v : v;
      end
   endtask

   task automatic send_frame(input logic [7:0] b, input logic pb, input logic sb,
                             input bit noisy);
      drive_bit(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) drive_bit(b[i], noisy);
      drive_bit(pb, 1'b0);
      drive_bit(sb, 1'b0);
      repeat (4) begin
         @(negedge clk);
         rx_line = sb ? 1'b1 : 1'b0;
      end
   endtask

   task automatic do_read();
      @(negedge clk) rd_n = 1'b0;
      @(negedge clk) rd_n = 1'b1;
   endtask

   function automatic logic good_par(input logic [7:0] b, input logic odd);
      return (^b) ^ odd;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(st() == 0 && dout == 0, "R1 reset flags/dout", {st(), dout}, 0);

      // R7: read with nothing pending
      do_read();
      chk(ready == 0 && overrun == 0, "R7 read while empty", st(), 0);

      // R3 R4 R5 R7 R9: sweep all bytes, both parities, half with edge noise
      for (int p = 0; p < 2; p++) begin
         parity_odd = p[0];
         for (int b = 0; b < 256; b++) begin
            send_frame(b[7:0], good_par(b[7:0], p[0]), 1'b1, b[0]);
            chk(st() == 4'b1000, "R5 R9 R7 flags after good frame", st(), 4'b1000);
            do_read();
            chk(dout == b[7:0] && ready == 0, "R3 R4 byte after read",
                {ready, dout}, b);
         end
      end

      // R5: wrong parity, both senses, then a good frame clears it (R9)
      for (int p = 0; p < 2; p++) begin
         parity_odd = p[0];
         send_frame(8'hA5, ~good_par(8'hA5, p[0]), 1'b1, 1'b0);
         chk(parity_err == 1 && frame_err == 0, "R5 parity mismatch", st(), 4'b1100);
         do_read();
         chk(dout == 8'hA5, "R5 byte kept on parity error", dout, 8'hA5);
         send_frame(8'h3C, good_par(8'h3C, p[0]), 1'b1, 1'b0);
         chk(parity_err == 0, "R9 parity flag rewritten", st(), 4'b1000);
         do_read();
      end

      // R6: low stop bit, then a break held low
      parity_odd = 1'b0;
      send_frame(8'h5A, good_par(8'h5A, 1'b0), 1'b0, 1'b0);
      chk(frame_err == 1 && ready == 1, "R6 frame error flagged", st(), 4'b1010);
      do_read();
      repeat (40) @(negedge clk);
      rx_line = 1'b1;
      repeat (40) @(negedge clk);
      chk(ready == 0, "R6 no frame restarted during break", st(), 0);
      send_frame(8'hC3, good_par(8'hC3, 1'b0), 1'b1, 1'b0);
      chk(frame_err == 0 && ready == 1, "R9 frame flag rewritten", st(), 4'b1000);
      do_read();
      chk(dout == 8'hC3, "R6 recovery byte", dout, 8'hC3);

      // R2: short glitch
      @(negedge clk) rx_line = 1'b0;
      repeat (3) @(negedge clk);
      @(negedge clk) rx_line = 1'b1;
      repeat (60) @(negedge clk);
      chk(ready == 0, "R2 glitch gives no byte", st(), 0);
      send_frame(8'h81, good_par(8'h81, 1'b0), 1'b1, 1'b1);
      do_read();
      chk(dout == 8'h81, "R2 frame after glitch", dout, 8'h81);

      // R8: overrun
      send_frame(8'h11, good_par(8'h11, 1'b0), 1'b1, 1'b0);
      chk(overrun == 0, "R8 no overrun on first", st(), 4'b1000);
      send_frame(8'h22, good_par(8'h22, 1'b0), 1'b1, 1'b0);
      chk(overrun == 1 && ready == 1, "R8 overrun set", st(), 4'b1001);
      do_read();
      chk(dout == 8'h22 && overrun == 0 && ready == 0, "R8 newest byte, flag cleared",
          {st(), dout}, 8'h22);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule